// File: doc/BRIEF.md
# Store/Busy Pin Sequencer for a Nonvolatile-Backed SRAM

This block decides when the contents of an SRAM array are copied into their nonvolatile shadow (a store) and when the shadow is copied back (a recall). It also owns a bidirectional open-drain pin. The pin has two jobs: it carries busy status out of the block, and any external agent can pull it low to request a store.

A store request can come from three places: the pin going low, a software strobe, or a power-fail strobe. A pin request or a power-fail request is acted on only if an SRAM write has completed since the last store or recall. A software store always runs.

Once a store is accepted, the block pulls the pin low and opens a short grace window. During the window a read or write already on the array can finish. Reads stay allowed, but new writes are refused. After the window the block runs an erase phase and then a program phase, with all array access gated. It then releases the pin and keeps the array closed until the pin is sampled high again.

A recall runs as a clear phase followed by a transfer phase. It does not touch the pin. If the pin is still sampled high at the end of the grace window because something outside holds it up, the store is abandoned and the write-dirty state is kept.

Top module: `nvs_busy_seq`

## Requirements
- R1: After reset the pin is not driven, reads and writes are both allowed and no array phase is active.
- R2: When idle with the pin sampled low, a store runs if a write has completed since the last store or recall. If none has, no store runs, reads stay allowed and writes are refused until the pin is sampled high.
- R3: The pin is driven low for the whole grace window, erase phase and program phase, whatever requested the store. It is released when the program phase ends.
- R4: During the grace window reads are allowed and writes are not. The window lasts SYNC_STAGES+2 cycles when no SRAM cycle is in flight, and GRACE_CYC cycles when one stays in flight.
- R5: Writes are allowed only in the idle state, so they are refused from the moment a request is accepted until the pin is sampled high again.
- R6: After the program phase, reads and writes stay refused for as long as the pin is sampled low.
- R7: A store is an erase phase of ERASE_CYC cycles followed directly by a program phase of PROG_CYC cycles, with reads and writes refused throughout. At most one phase output is high at any time.
- R8: A recall is a clear phase of CLEAR_CYC cycles followed directly by a transfer phase of XFER_CYC cycles. Access is refused throughout and the pin is not driven.
- R9: A completed write marks the array dirty. The mark is cleared when an erase or clear phase begins. A power-fail request with no mark is ignored. A software store runs whether or not the mark is set.
- R10: If the pin is still sampled high at the end of the grace window, the store is abandoned: the pin is released, no erase runs, the block returns to idle and the dirty mark is kept.
- R11: When several requests arrive in the same idle cycle, the pin takes priority, then power-fail, then software store, then software recall. Requests that arrive outside the idle state are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | Raw level read back from the store/busy pin |
| sw_store_req | input | 1 | Software store strobe |
| sw_recall_req | input | 1 | Software recall strobe |
| pwr_fail_req | input | 1 | Power-fail store strobe |
| sram_busy | input | 1 | An SRAM read or write cycle is in flight |
| sram_wr_done | input | 1 | One-cycle strobe marking a completed SRAM write |
| pin_drive_low | output | 1 | Open-drain pull-down enable for the pin |
| rd_allow | output | 1 | New SRAM reads may start |
| wr_allow | output | 1 | New SRAM writes may start |
| erase_en | output | 1 | Nonvolatile erase phase active |
| prog_en | output | 1 | Nonvolatile program phase active |
| clear_en | output | 1 | SRAM clear phase of a recall active |
| xfer_en | output | 1 | Nonvolatile-to-SRAM transfer phase active |

## Verification
The assertions assume that pin_in follows the open-drain wire. Once pin_drive_low is high, the pin reads low after the synchronizer delay, unless something outside deliberately holds it high. The bench builds pin_in from the drive output, an external pull-down and an external hold-high, so this assumption always holds. The bench also gives each strobe for exactly one cycle, while the block is idle or on purpose outside it. It holds sram_busy steady across a whole request, so every grace window takes one of the two lengths it predicts.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_PINHOLD = 3'd1,
      ST_GRACE   = 3'd2,
      ST_ERASE   = 3'd3,
      ST_PROG    = 3'd4,
      ST_WAITHI  = 3'd5,
      ST_CLEAR   = 3'd6,
      ST_XFER    = 3'd7
   } nvs_state_e;

   function automatic int unsigned nvs_max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/nvs_pin_sync.sv
module nvs_pin_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_raw,
   output logic pin_level
);
   generate
      if (STAGES == 0) begin : g_bypass
         logic unused_sync_ports;
         assign unused_sync_ports = clk ^ rst_n;
         assign pin_level = pin_raw;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '1;
            else if (STAGES == 1) sh <= pin_raw;
            else sh <= {sh[STAGES-2:0], pin_raw};
         end
         assign pin_level = sh[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/nvs_dirty_flag.sv
module nvs_dirty_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_done,
   input  logic clr,
   output logic dirty
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dirty <= 1'b0;
      else if (clr)     dirty <= 1'b0;
      else if (wr_done) dirty <= 1'b1;
   end
endmodule

// File: rtl/nvs_phase_timer.sv
module nvs_phase_timer #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   output logic [W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        count <= '0;
      else if (restart)  count <= '0;
      else if (!(&count)) count <= count + 1'b1;
   end
endmodule

// File: rtl/nvs_busy_seq.sv
module nvs_busy_seq
   import nvs_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned GRACE_CYC   = 250,
   parameter int unsigned ERASE_CYC   = 1250000,
   parameter int unsigned PROG_CYC    = 1250000,
   parameter int unsigned CLEAR_CYC   = 16,
   parameter int unsigned XFER_CYC    = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_in,
   input  logic sw_store_req,
   input  logic sw_recall_req,
   input  logic pwr_fail_req,
   input  logic sram_busy,
   input  logic sram_wr_done,
   output logic pin_drive_low,
   output logic rd_allow,
   output logic wr_allow,
   output logic erase_en,
   output logic prog_en,
   output logic clear_en,
   output logic xfer_en
);
   localparam int unsigned MAX_CYC = nvs_max2(nvs_max2(GRACE_CYC, nvs_max2(ERASE_CYC, PROG_CYC)),
                                              nvs_max2(CLEAR_CYC, XFER_CYC));
   localparam int unsigned TW = $clog2(MAX_CYC + 1);
   localparam logic [TW-1:0] GRACE_MIN  = TW'(SYNC_STAGES + 1);
   localparam logic [TW-1:0] GRACE_LAST = TW'(GRACE_CYC - 1);
   localparam logic [TW-1:0] ERASE_LAST = TW'(ERASE_CYC - 1);
   localparam logic [TW-1:0] PROG_LAST  = TW'(PROG_CYC - 1);
   localparam logic [TW-1:0] CLEAR_LAST = TW'(CLEAR_CYC - 1);
   localparam logic [TW-1:0] XFER_LAST  = TW'(XFER_CYC - 1);

   generate
      if (GRACE_CYC < SYNC_STAGES + 2) begin : g_bad_grace
         $error("GRACE_CYC must cover the pin synchronizer delay");
      end
      if (ERASE_CYC == 0 || PROG_CYC == 0 || CLEAR_CYC == 0 || XFER_CYC == 0) begin : g_bad_phase
         $error("every array phase needs at least one cycle");
      end
   endgenerate

   nvs_state_e  st, nx;
   logic        pin_lvl;
   logic        dirty;
   logic        dirty_clr;
   logic        restart;
   logic [TW-1:0] cnt;

   nvs_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_raw(pin_in), .pin_level(pin_lvl)
   );

   nvs_dirty_flag u_dirty (
      .clk(clk), .rst_n(rst_n), .wr_done(sram_wr_done), .clr(dirty_clr), .dirty(dirty)
   );

   nvs_phase_timer #(.W(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .restart(restart), .count(cnt)
   );

   always_comb begin
      nx = st;
      unique case (st)
         ST_IDLE: begin
            if (!pin_lvl)          nx = dirty ? ST_GRACE : ST_PINHOLD;
            else if (pwr_fail_req) nx = dirty ? ST_GRACE : ST_IDLE;
            else if (sw_store_req) nx = ST_GRACE;
            else if (sw_recall_req) nx = ST_CLEAR;
         end
         ST_PINHOLD: if (pin_lvl) nx = ST_IDLE;
         ST_GRACE: begin
            if (cnt >= GRACE_MIN && (!sram_busy || cnt >= GRACE_LAST))
               nx = pin_lvl ? ST_IDLE : ST_ERASE;
         end
         ST_ERASE:  if (cnt == ERASE_LAST) nx = ST_PROG;
         ST_PROG:   if (cnt == PROG_LAST)  nx = ST_WAITHI;
         ST_WAITHI: if (pin_lvl)           nx = ST_IDLE;
         ST_CLEAR:  if (cnt == CLEAR_LAST) nx = ST_XFER;
         ST_XFER:   if (cnt == XFER_LAST)  nx = ST_IDLE;
         default:   nx = ST_IDLE;
      endcase
   end

   assign restart   = (nx != st);
   assign dirty_clr = restart && (nx == ST_ERASE || nx == ST_CLEAR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= nx;
   end

   assign pin_drive_low = (st == ST_GRACE) || (st == ST_ERASE) || (st == ST_PROG);
   assign rd_allow      = (st == ST_IDLE) || (st == ST_PINHOLD) || (st == ST_GRACE);
   assign wr_allow      = (st == ST_IDLE);
   assign erase_en      = (st == ST_ERASE);
   assign prog_en       = (st == ST_PROG);
   assign clear_en      = (st == ST_CLEAR);
   assign xfer_en       = (st == ST_XFER);

   AST_STORE_DRIVES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_en || prog_en) |-> pin_drive_low);                                  // R3
   AST_NO_WR_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      pin_drive_low |-> !wr_allow);                                              // R5
   AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({erase_en, prog_en, clear_en, xfer_en}));                         // R7
   AST_ERASE_THEN_PROG: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(erase_en) |-> prog_en);                                              // R7
   AST_CLEAR_THEN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clear_en) |-> xfer_en);                                              // R8
   AST_RECALL_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_en || xfer_en) |-> (!pin_drive_low && !rd_allow));                  // R8
   AST_PROG_END_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(prog_en) |-> (!pin_drive_low && !rd_allow && !wr_allow));            // R6
   AST_ERASE_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(erase_en) |-> !pin_lvl);                                             // R10
   AST_IDLE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(wr_allow) && $past(st == ST_WAITHI || st == ST_PINHOLD)) |-> pin_lvl); // R2
endmodule

// File: tb/nvs_busy_seq_bench.sv
module nvs_busy_seq_bench;
   localparam int SYNC  = 2;
   localparam int GRACE = 16;
   localparam int ERASE = 5;
   localparam int PROG  = 7;
   localparam int CLR   = 3;
   localparam int XFER  = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sw_store = 1'b0, sw_recall = 1'b0, pwr_fail = 1'b0;
   logic sram_busy = 1'b0, wr_done = 1'b0;
   logic ext_low = 1'b0, ext_high = 1'b0;
   logic pin_in, drive, rd_ok, wr_ok, er, pg, cl, xf;

   int checks = 0, failures = 0;
   int n_er, n_pg, n_cl, n_xf, n_drv, n_wr_busy, n_rd_phase, n_rd_drv;
   bit done = 1'b0;
   bit model_dirty = 1'b0;

   always #2 clk = ~clk;

   assign pin_in = ext_high ? 1'b1 : !(drive || ext_low);

   nvs_busy_seq #(.SYNC_STAGES(SYNC), .GRACE_CYC(GRACE), .ERASE_CYC(ERASE),
                  .PROG_CYC(PROG), .CLEAR_CYC(CLR), .XFER_CYC(XFER)) u_nvs_busy_seq (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .sw_store_req(sw_store),
      .sw_recall_req(sw_recall), .pwr_fail_req(pwr_fail), .sram_busy(sram_busy),
      .sram_wr_done(wr_done), .pin_drive_low(drive), .rd_allow(rd_ok), .wr_allow(wr_ok),
      .erase_en(er), .prog_en(pg), .clear_en(cl), .xfer_en(xf));

   function automatic int exp_drive(input bit runs, input bit busy_held);
      if (!runs) return 0;
      return (busy_held ? GRACE : SYNC + 2) + ERASE + PROG;
   endfunction

   task automatic check_eq(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic observe(input int n);
      n_er = 0; n_pg = 0; n_cl = 0; n_xf = 0; n_drv = 0;
      n_wr_busy = 0; n_rd_phase = 0; n_rd_drv = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         sw_store = 1'b0; sw_recall = 1'b0; pwr_fail = 1'b0; wr_done = 1'b0;
         n_er += int'(er); n_pg += int'(pg); n_cl += int'(cl); n_xf += int'(xf);
         n_drv += int'(drive);
         n_wr_busy  += int'(wr_ok && (drive || er || pg || cl || xf));
         n_rd_phase += int'(rd_ok && (er || pg || cl || xf));
         n_rd_drv   += int'(rd_ok && drive);
      end
   endtask

   task automatic do_write();
      wr_done = 1'b1;
      observe(1);
      model_dirty = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++; checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_eq("R1 drive", int'(drive), 0);
      check_eq("R1 access", int'(rd_ok && wr_ok), 1);
      check_eq("R1 phases", int'(er | pg | cl | xf), 0);

      // software store after a write, no cycle in flight
      do_write();
      sw_store = 1'b1; observe(40);
      check_eq("R7 erase cycles", n_er, ERASE);
      check_eq("R7 prog cycles", n_pg, PROG);
      check_eq("R3 drive cycles", n_drv, exp_drive(1, 0));
      check_eq("R5 write during busy", n_wr_busy, 0);
      check_eq("R7 read in phase", n_rd_phase, 0);
      check_eq("R4 reads in short grace", n_rd_drv, SYNC + 2);
      check_eq("R6 access restored", int'(rd_ok && wr_ok), 1);
      model_dirty = 0;

      // store cleared the mark: power-fail is ignored
      pwr_fail = 1'b1; observe(40);
      check_eq("R9 clean power-fail", n_er + n_drv, 0);
      // software store runs with no mark
      sw_store = 1'b1; observe(40);
      check_eq("R9 clean sw store", n_er, ERASE);

      // pin request with mark, pin held low past the store
      do_write();
      ext_low = 1'b1; observe(40);
      check_eq("R2 pin store erase", n_er, ERASE);
      check_eq("R3 pin store drive", n_drv, exp_drive(1, 0));
      check_eq("R6 held after store", int'(rd_ok || wr_ok), 0);
      ext_low = 1'b0; observe(6);
      check_eq("R6 released", int'(rd_ok && wr_ok), 1);
      model_dirty = 0;

      // pin request with no mark
      ext_low = 1'b1; observe(20);
      check_eq("R2 clean pin no store", n_er + n_drv, 0);
      check_eq("R2 reads kept", int'(rd_ok), 1);
      check_eq("R5 writes refused", int'(wr_ok), 0);
      ext_low = 1'b0; observe(6);
      check_eq("R2 writes back", int'(wr_ok), 1);

      // long grace with a cycle in flight
      sram_busy = 1'b1;
      sw_store = 1'b1; observe(50);
      check_eq("R4 long grace drive", n_drv, exp_drive(1, 1));
      check_eq("R4 reads in long grace", n_rd_drv, GRACE);
      check_eq("R5 write in long grace", n_wr_busy, 0);
      sram_busy = 1'b0;

      // abandon: pin held high externally
      do_write();
      ext_high = 1'b1;
      pwr_fail = 1'b1; observe(30);
      check_eq("R10 no erase", n_er, 0);
      check_eq("R10 drive released", n_drv, SYNC + 2);
      check_eq("R10 back to idle", int'(wr_ok), 1);
      ext_high = 1'b0; observe(4);
      pwr_fail = 1'b1; observe(40);
      check_eq("R10 mark kept", n_er, ERASE);
      model_dirty = 0;

      // recall clears the mark
      do_write();
      sw_recall = 1'b1; observe(20);
      check_eq("R8 clear cycles", n_cl, CLR);
      check_eq("R8 xfer cycles", n_xf, XFER);
      check_eq("R8 no drive", n_drv, 0);
      check_eq("R8 access gated", n_wr_busy + n_rd_phase, 0);
      model_dirty = 0;
      pwr_fail = 1'b1; observe(30);
      check_eq("R9 recall cleared mark", n_er, 0);

      // priority and requests while busy
      sw_store = 1'b1; sw_recall = 1'b1; observe(40);
      check_eq("R11 store over recall", n_er, ERASE);
      check_eq("R11 recall dropped", n_cl, 0);
      sw_store = 1'b1; observe(3);
      sw_recall = 1'b1; observe(40);
      check_eq("R11 recall during store ignored", n_cl, 0);

      // random mix against the dirty-mark model
      for (int it = 0; it < 40; it++) begin
         int nw, op;
         bit runs;
         nw = int'($urandom % 3);
         for (int k = 0; k < nw; k++) do_write();
         op = int'($urandom % 3);
         case (op)
            0: pwr_fail = 1'b1;
            1: sw_store = 1'b1;
            default: sw_recall = 1'b1;
         endcase
         runs = (op == 1) || (op == 0 && model_dirty);
         observe(40);
         check_eq("R9 random erase", n_er, runs ? ERASE : 0);
         check_eq("R8 random clear", n_cl, (op == 2) ? CLR : 0);
         check_eq("R5 random gating", n_wr_busy, 0);
         if (runs || op == 2) model_dirty = 0;
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule